// File: doc/BRIEF.md
# Quadratic Phase Accumulator

This block produces one phase word per input sample for a quadrature mixer that sits in front of a polyphase filter bank. The phase follows a second-order polynomial in the sample index, p0 + p1·n + p2·n². It is built from additions only, with no multiplier. A load strobe brings in the three coefficients at the start of a scan or an integration and restarts the index at zero. Each sample strobe then releases the current phase and advances the state by a forward-difference step.

The step applied after sample n is p1 + p2 + 2·(sum of p2 over the earlier samples). A parameter chooses how that step is formed. In one variant it is a register that grows by 2·p2 each sample. In the other it is computed on the spot from p1, p2 and a running sum of p2. Both variants give identical outputs.

A wrap input, qualified by the sample strobe, adds an external offset to the output phase. The offset is normally a quarter cycle. It adds to that sample and to every later one, and builds up until the next load. All arithmetic is modulo 2^W, so the phase word is a fraction of a full turn.

Top module: `quad_phase_gen`

## Requirements
- R1: While reset is asserted and after it is released, valid_o is low and phase_o is zero until the first sample strobe; the accumulated wrap offset starts at zero.
- R2: A cycle with load_i high captures p0_i, p1_i and p2_i together, clears the accumulated wrap offset and restarts the sample index at n = 0, so the first sample after the load outputs p0 (plus any wrap offset given with that sample).
- R3: The n-th sample strobe after a load (n counting from 0) outputs p0 + p1·n + p2·n² modulo 2^W, plus the accumulated wrap offset.
- R4: The phase only advances on sample strobes. In a cycle without sample_i, phase_o holds its value and valid_o is low one cycle later.
- R5: For a sample strobe in cycle k, the phase appears on phase_o with valid_o high in cycle k+1. valid_o is never high unless the previous cycle carried a sample strobe without a load.
- R6: wrap_i high together with sample_i adds wrap_ofs_i to that sample's phase and to every later output until the next load. Several wraps add up.
- R7: wrap_i without sample_i is ignored. Neither the current output nor any later output changes because of it.
- R8: When load_i and sample_i are high in the same cycle, the load takes effect, no output is produced (valid_o low next cycle) and the sample is not counted.
- R9: All sums wrap modulo 2^W; coefficients whose products overflow W bits still give the truncated polynomial value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Load strobe: capture coefficients, restart sequence |
| p0_i | input | W | Constant phase term |
| p1_i | input | W | Linear phase coefficient |
| p2_i | input | W | Quadratic phase coefficient |
| sample_i | input | 1 | One pulse per input sample; advances the phase |
| wrap_i | input | 1 | Delay wrap flag, qualified by sample_i |
| wrap_ofs_i | input | W | Offset added on a wrap (normally a quarter cycle) |
| valid_o | output | 1 | Phase word valid, one cycle per sample |
| phase_o | output | W | Phase word for the mixer |

## Verification
The main function is driven with a pure constant load (p1 = p2 = 0), a pure linear ramp (p2 = 0) and full random 48-bit coefficients. These show, in turn, that the seed, the first difference and the second-difference term each enter correctly. Random coefficients large enough to overflow the word check the modulo arithmetic against a direct truncated evaluation of the polynomial. Samples spaced by idle cycles tell a per-sample update apart from a per-clock one. Wraps given with and without a sample, a reload in the middle of a run, and a load colliding with a sample show that the offset builds up only on qualified samples and that a load both restarts the index and clears the offset.

// File: rtl/qpa_pkg.sv
package qpa_pkg;
   // How the per-sample increment is formed
   typedef enum logic [0:0] {
      INC_DIRECT = 1'b0,   // p1 + p2 + 2*sum(p2), computed each cycle
      INC_RECUR  = 1'b1    // registered increment, advanced by 2*p2
   } inc_style_e;

   localparam int unsigned MIN_W = 8;
   localparam int unsigned MAX_W = 64;
endpackage

// File: rtl/qpa_diff_engine.sv
module qpa_diff_engine
   import qpa_pkg::*;
#(
   parameter int unsigned W     = 48,
   parameter inc_style_e  STYLE = INC_RECUR
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic         step_i,
   input  logic [W-1:0] p1_i,
   input  logic [W-1:0] p2_i,
   output logic [W-1:0] inc_o
);
   localparam logic [W-1:0] ZERO = '0;

   logic [W-1:0] c2_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      c2_q <= ZERO;
      else if (load_i) c2_q <= p2_i;
   end

   generate
      if (STYLE == INC_RECUR) begin : g_recur
         logic [W-1:0] inc_q;
         always_ff @(posedge clk) begin
            if (!rst_n)      inc_q <= ZERO;
            else if (load_i) inc_q <= p1_i + p2_i;
            else if (step_i) inc_q <= inc_q + {c2_q[W-2:0], 1'b0};
         end
         assign inc_o = inc_q;
      end else begin : g_direct
         logic [W-1:0] c1_q;
         logic [W-1:0] sum_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               c1_q  <= ZERO;
               sum_q <= ZERO;
            end else if (load_i) begin
               c1_q  <= p1_i;
               sum_q <= ZERO;
            end else if (step_i) begin
               sum_q <= sum_q + c2_q;
            end
         end
         assign inc_o = c1_q + c2_q + {sum_q[W-2:0], 1'b0};
      end
   endgenerate

   // R2
   inc_coef_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(c2_q));
endmodule

// File: rtl/qpa_phase_acc.sv
module qpa_phase_acc #(
   parameter int unsigned W = 48
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] p0_i,
   input  logic         sample_i,
   input  logic         wrap_i,
   input  logic [W-1:0] wrap_ofs_i,
   input  logic [W-1:0] inc_i,
   output logic         valid_o,
   output logic [W-1:0] phase_o
);
   localparam logic [W-1:0] ZERO = '0;

   logic [W-1:0] acc_q;
   logic [W-1:0] off_q;
   logic [W-1:0] wrap_add;
   logic [W-1:0] off_next;
   logic         step;

   assign step     = sample_i & ~load_i;
   assign wrap_add = wrap_i ? wrap_ofs_i : ZERO;
   assign off_next = off_q + wrap_add;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q   <= ZERO;
         off_q   <= ZERO;
         phase_o <= ZERO;
         valid_o <= 1'b0;
      end else begin
         valid_o <= step;
         if (load_i) begin
            acc_q <= p0_i;
            off_q <= ZERO;
         end else if (sample_i) begin
            phase_o <= acc_q + off_next;
            off_q   <= off_next;
            acc_q   <= acc_q + inc_i;
         end
      end
   end

   // R5
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> $past(sample_i && !load_i));

   // R4
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_i |=> ($stable(phase_o) && !valid_o));

   // R7
   wrap_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sample_i && !load_i) |=> ($stable(off_q) && $stable(acc_q)));

   // R8
   load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> !valid_o);
endmodule

// File: rtl/quad_phase_gen.sv
module quad_phase_gen
   import qpa_pkg::*;
#(
   parameter int unsigned W     = 48,
   parameter inc_style_e  STYLE = INC_RECUR
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] p0_i,
   input  logic [W-1:0] p1_i,
   input  logic [W-1:0] p2_i,
   input  logic         sample_i,
   input  logic         wrap_i,
   input  logic [W-1:0] wrap_ofs_i,
   output logic         valid_o,
   output logic [W-1:0] phase_o
);
   generate
      if (W < MIN_W || W > MAX_W) begin : g_bad_width
         $error("quad_phase_gen: W out of range");
      end
   endgenerate

   logic [W-1:0] inc;
   logic         step;

   assign step = sample_i & ~load_i;

   qpa_diff_engine #(.W(W), .STYLE(STYLE)) u_diff (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load_i),
      .step_i (step),
      .p1_i   (p1_i),
      .p2_i   (p2_i),
      .inc_o  (inc)
   );

   qpa_phase_acc #(.W(W)) u_acc (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load_i),
      .p0_i       (p0_i),
      .sample_i   (sample_i),
      .wrap_i     (wrap_i),
      .wrap_ofs_i (wrap_ofs_i),
      .inc_i      (inc),
      .valid_o    (valid_o),
      .phase_o    (phase_o)
   );

   // R2
   seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i ##1 (sample_i && !load_i && !wrap_i)) |=> (phase_o == $past(p0_i, 2)));
endmodule

// File: tb/tb_quad_phase_gen.sv
module tb_quad_phase_gen;
   localparam int unsigned W = 48;
   typedef logic [W-1:0] word_t;

   logic  clk = 1'b0;
   logic  rst_n = 1'b0;
   logic  load_i = 1'b0;
   word_t p0_i = '0, p1_i = '0, p2_i = '0;
   logic  sample_i = 1'b0;
   logic  wrap_i = 1'b0;
   word_t wrap_ofs_i = '0;
   logic  valid_o;
   word_t phase_o;

   int    n_tests = 0;
   int    n_fail  = 0;
   bit    done    = 0;

   // bench-side model state
   word_t m_p0, m_p1, m_p2, m_off, m_n;

   always #10 clk = ~clk;

   quad_phase_gen #(.W(W)) dut (
      .clk(clk), .rst_n(rst_n), .load_i(load_i),
      .p0_i(p0_i), .p1_i(p1_i), .p2_i(p2_i),
      .sample_i(sample_i), .wrap_i(wrap_i), .wrap_ofs_i(wrap_ofs_i),
      .valid_o(valid_o), .phase_o(phase_o)
   );

   function automatic word_t rnd_word();
      return word_t'({$urandom, $urandom});
   endfunction

   function automatic word_t expect_phase();
      return m_p0 + m_p1 * m_n + m_p2 * m_n * m_n + m_off;
   endfunction

   task automatic check(input bit ok, input string req, input word_t act, input word_t exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_load(input word_t a, input word_t b, input word_t c);
      p0_i = a; p1_i = b; p2_i = c; load_i = 1'b1;
      @(negedge clk);
      load_i = 1'b0;
      m_p0 = a; m_p1 = b; m_p2 = c; m_off = '0; m_n = '0;
   endtask

   // one sample strobe, checked on the following cycle
   task automatic do_sample(input bit wr, input word_t ofs, input string req);
      word_t e;
      sample_i = 1'b1; wrap_i = wr; wrap_ofs_i = ofs;
      @(negedge clk);
      sample_i = 1'b0; wrap_i = 1'b0;
      if (wr) m_off = m_off + ofs;
      e = expect_phase();
      check(valid_o == 1'b1, {req, " valid"}, word_t'(valid_o), word_t'(1));
      check(phase_o == e, req, phase_o, e);
      m_n = m_n + 1;
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      check(valid_o == 1'b0, "R1 valid in reset", word_t'(valid_o), '0);
      check(phase_o == '0, "R1 phase in reset", phase_o, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check(valid_o == 1'b0, "R1 valid after reset", word_t'(valid_o), '0);
      check(phase_o == '0, "R1 phase after reset", phase_o, '0);
   endtask

   task automatic t_constant();
      do_load(48'h1234_5678_9ABC, '0, '0);
      for (int i = 0; i < 4; i++) do_sample(1'b0, '0, "R2 constant seed");
   endtask

   task automatic t_linear();
      do_load(48'h10, 48'h0000_0100_0000, '0);
      for (int i = 0; i < 8; i++) do_sample(1'b0, '0, "R3 linear ramp");
   endtask

   task automatic t_random_quad();
      for (int k = 0; k < 6; k++) begin
         do_load(rnd_word(), rnd_word(), rnd_word());
         for (int i = 0; i < 40; i++) do_sample(1'b0, '0, "R3 R9 random quadratic");
      end
   endtask

   task automatic t_gaps();
      word_t held;
      do_load(rnd_word(), rnd_word(), rnd_word());
      for (int i = 0; i < 6; i++) begin
         do_sample(1'b0, '0, "R5 spaced sample");
         held = phase_o;
         repeat (i % 3 + 1) begin
            @(negedge clk);
            check(valid_o == 1'b0, "R4 idle valid low", word_t'(valid_o), '0);
            check(phase_o == held, "R4 idle phase held", phase_o, held);
         end
      end
   endtask

   task automatic t_wrap();
      word_t q = word_t'(1) << (W - 2);
      do_load(rnd_word(), rnd_word(), rnd_word());
      do_sample(1'b0, '0, "R6 before wrap");
      do_sample(1'b1, q, "R6 first wrap");
      do_sample(1'b0, '0, "R6 offset persists");
      // R7: wrap without a sample
      wrap_i = 1'b1; wrap_ofs_i = q;
      @(negedge clk);
      wrap_i = 1'b0;
      check(valid_o == 1'b0, "R7 lone wrap no output", word_t'(valid_o), '0);
      do_sample(1'b0, '0, "R7 lone wrap ignored");
      do_sample(1'b1, q, "R6 second wrap adds up");
      do_sample(1'b0, '0, "R6 accumulated offset");
      // reload clears the offset
      do_load(m_p0, m_p1, m_p2);
      do_sample(1'b0, '0, "R2 load clears offset");
   endtask

   task automatic t_collide();
      do_load(rnd_word(), rnd_word(), rnd_word());
      for (int i = 0; i < 5; i++) do_sample(1'b0, '0, "R3 before reload");
      // load and sample together
      p0_i = rnd_word(); p1_i = rnd_word(); p2_i = rnd_word();
      load_i = 1'b1; sample_i = 1'b1;
      @(negedge clk);
      load_i = 1'b0; sample_i = 1'b0;
      m_p0 = p0_i; m_p1 = p1_i; m_p2 = p2_i; m_off = '0; m_n = '0;
      @(negedge clk);
      check(valid_o == 1'b0, "R8 load beats sample", word_t'(valid_o), '0);
      for (int i = 0; i < 5; i++) do_sample(1'b0, '0, "R8 R2 restart at n=0");
   endtask

   task automatic t_overflow();
      do_load({W{1'b1}}, {W{1'b1}}, word_t'(1) << (W - 1));
      for (int i = 0; i < 10; i++) do_sample(1'b0, '0, "R9 modulo wrap");
   endtask

   initial begin
      t_reset();
      t_constant();
      t_linear();
      t_random_quad();
      t_gaps();
      t_wrap();
      t_collide();
      t_overflow();
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule